// File: doc/BRIEF.md
# Descriptor List Stream DMA Tracker

This block keeps the position of a set of audio stream DMA channels. Each channel walks a cyclic buffer whose pieces are listed in a descriptor table held in memory. When software sets a channel's run bit, the block reads that channel's descriptors through a memory read port into a small local table. A codec then asks for N bytes on a stream. The block finds the matching channel and cuts the request into memory burst commands, each given as an address and a length. No burst crosses the end of a descriptor or the end of the cyclic buffer.

For each channel the block tracks three values: the link position in the cyclic buffer, the current descriptor index and the byte offset inside that descriptor. At the end of each request it can store the link position into a position buffer in memory. When an entry that carries the completion flag is used up, it sets that channel's completion status. The block does not move sample data and does not interpret audio formats.

Top module: `dsdma_tracker`

## Requirements
- R1: After reset, every channel's control word reads 0x2000_0000, meaning FIFO ready with all other bits zero. Link positions read 0, no completion status is set, and no request, burst or position write is active.
- R2: When the run bit (control bit 1) changes from 0 to 1, the block reads last-index+1 descriptors, one per read, at list base + 16*k for k = 0, 1, .... The list base ignores its low 7 bits. A descriptor word carries the address in bits 63:0, the length in bits 95:64 and the completion flag in bit 96.
- R3: Each chunk is the smallest of three values: the bytes still requested, the cyclic length minus the link position, and the entry length minus the entry offset. The burst address is the entry address plus the entry offset. A chunk of zero bytes issues no burst.
- R4: When an entry is used up, the entry offset returns to 0 and the entry index advances. After the last entry, the entry index and the link position both return to 0.
- R5: One request makes at most as many chunks as the channel has entries. The request is then answered by a one-cycle done pulse.
- R6: When position-buffer base bit 0 is set, each completed request writes the link position to (base with bit 0 cleared) + 8*channel. When that bit is clear, no position write takes place.
- R7: If a request uses up an entry whose flag is set, control bit 26 and that channel's interrupt output are set by the time done is seen. Writing 1 to bit 26 clears it. Writing 0 leaves it unchanged.
- R8: Writing control bit 0 as 1 sets the control word to 0x2000_0000, which stops the channel.
- R9: A request whose direction input is 1 searches channels 4 to 7. Otherwise it searches channels 0 to 3. It picks the lowest-numbered channel in that group whose control bits 23:20 equal the requested stream number.
- R10: A request is answered with done and error, with no burst and no change of position, in three cases: no channel matches, the matched channel is not running, or its descriptors are not loaded.
- R11: Restarting a channel (run bit 0 and then 1) sets its link position, entry index and entry offset back to 0.
- R12: Register select codes are: 0 control, 1 cyclic length, 2 last index, 3 and 4 list base low and high, 5 link position (read only), 6 and 7 position-buffer base low and high. The position-buffer base is shared by all channels and its low word keeps only bits 31:7 and bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regStream | input | 3 | Channel addressed by a register access |
| regSel | input | 3 | Register select code (R12) |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regStream/regSel, combinational |
| memRdReq | output | 1 | Descriptor read request, held until acknowledged |
| memRdAddr | output | 64 | Descriptor byte address |
| memRdAck | input | 1 | Descriptor data valid |
| memRdData | input | 97 | Descriptor word, {flag, length, address} |
| xferReq | input | 1 | Codec transfer request, held until done |
| xferOutput | input | 1 | 1 for the output group, 0 for the input group |
| xferStreamNum | input | 4 | Requested stream number |
| xferLen | input | 32 | Requested byte count |
| xferDone | output | 1 | One-cycle completion of a request |
| xferErr | output | 1 | Marks a rejected request, valid with xferDone |
| burstValid | output | 1 | Burst command valid |
| burstReady | input | 1 | Burst command accepted |
| burstAddr | output | 64 | Burst start address |
| burstLen | output | 32 | Burst byte count |
| posWrValid | output | 1 | Position write valid |
| posWrReady | input | 1 | Position write accepted |
| posWrAddr | output | 64 | Position slot address |
| posWrData | output | 32 | Link position value |
| streamIrq | output | 8 | Per-channel completion status (control bit 26) |

## Verification
A wrong entry index or entry offset shows up at once on the next burst, as a wrong address or a chunk cut at the wrong place. It also shows up in the link position that is read back or written to the position buffer at the end of the same request. A missed wrap leaves the link position past the cyclic length, so the following request produces bursts of zero length that never appear. A lost completion flag is seen on the interrupt output when done arrives. Selection errors appear as a wrong error response on the very request that triggers them.

// File: rtl/dsdma_pkg.sv
package dsdma_pkg;
  localparam int ADDR_W = 64;
  localparam int DESC_W = 97;
  localparam logic [31:0] CTL_FIFO_RDY = 32'h2000_0000;
  localparam logic [31:0] CTL_RW_MASK  = 32'h00ff_001f;
  localparam logic [31:0] CTL_W1C_MASK = 32'h1c00_0000;
  localparam int CTL_IRQ_BIT = 26;
  localparam logic [31:0] BDL_LO_MASK = 32'hffff_ff80;
  localparam logic [31:0] DP_LO_MASK  = 32'hffff_ff81;

  localparam logic [2:0] SEL_CTL    = 3'd0;
  localparam logic [2:0] SEL_CBL    = 3'd1;
  localparam logic [2:0] SEL_LVI    = 3'd2;
  localparam logic [2:0] SEL_BDL_LO = 3'd3;
  localparam logic [2:0] SEL_BDL_HI = 3'd4;
  localparam logic [2:0] SEL_LPIB   = 3'd5;
  localparam logic [2:0] SEL_DP_LO  = 3'd6;
  localparam logic [2:0] SEL_DP_HI  = 3'd7;

  typedef struct packed {
    logic latchLoad;
    logic latchXfer;
    logic fetchStore;
    logic fetchDone;
    logic chunkStep;
    logic raiseIrq;
  } ctrlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CHUNK, ST_POSWR, ST_DONE, ST_ERR
  } ctrlState_e;
endpackage

// File: rtl/dsdma_ctrl.sv
module dsdma_ctrl
  import dsdma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        xferReq,
  input  logic        matchOk,
  input  logic        pendAny,
  input  logic        fetchLast,
  input  logic        memRdAck,
  input  logic        copyZero,
  input  logic        contAfter,
  input  logic        dpEnable,
  input  logic        burstReady,
  input  logic        posWrReady,
  output ctrlStrobe_t strobe,
  output logic        memRdReq,
  output logic        burstValid,
  output logic        posWrValid,
  output logic        xferDone,
  output logic        xferErr
);
  ctrlState_e state, stateNext;

  always_comb begin
    strobe     = '0;
    stateNext  = state;
    memRdReq   = 1'b0;
    burstValid = 1'b0;
    posWrValid = 1'b0;
    xferDone   = 1'b0;
    xferErr    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (pendAny) begin
          strobe.latchLoad = 1'b1;
          stateNext = ST_FETCH;
        end else if (xferReq) begin
          strobe.latchXfer = 1'b1;
          stateNext = matchOk ? ST_CHUNK : ST_ERR;
        end
      end
      ST_FETCH: begin
        memRdReq = 1'b1;
        if (memRdAck) begin
          strobe.fetchStore = 1'b1;
          if (fetchLast) begin
            strobe.fetchDone = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      ST_CHUNK: begin
        burstValid = !copyZero;
        if (copyZero || burstReady) begin
          strobe.chunkStep = 1'b1;
          stateNext = contAfter ? ST_CHUNK : ST_POSWR;
        end
      end
      ST_POSWR: begin
        posWrValid = dpEnable;
        if (!dpEnable || posWrReady) begin
          strobe.raiseIrq = 1'b1;
          stateNext = ST_DONE;
        end
      end
      ST_DONE: begin
        xferDone  = 1'b1;
        stateNext = ST_IDLE;
      end
      ST_ERR: begin
        xferDone  = 1'b1;
        xferErr   = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R3
  one_port_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({memRdReq, burstValid, posWrValid, xferDone}));
endmodule

// File: rtl/dsdma_datapath.sv
module dsdma_datapath
  import dsdma_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int MAX_ENTRIES = 4,
  localparam int SIDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int EIDX_W = (MAX_ENTRIES > 1) ? $clog2(MAX_ENTRIES) : 1,
  localparam int CNT_W  = $clog2(MAX_ENTRIES + 1),
  localparam int HALF   = NUM_STREAMS / 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  logic                   regWrEn,
  input  logic [SIDX_W-1:0]      regStream,
  input  logic [2:0]             regSel,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  input  logic                   xferOutput,
  input  logic [3:0]             xferStreamNum,
  input  logic [31:0]            xferLen,
  input  logic [DESC_W-1:0]      memRdData,
  input  logic                   burstValid,
  input  logic                   posWrValid,
  output logic [ADDR_W-1:0]      memRdAddr,
  output logic [ADDR_W-1:0]      burstAddr,
  output logic [31:0]            burstLen,
  output logic [ADDR_W-1:0]      posWrAddr,
  output logic [31:0]            posWrData,
  output logic [NUM_STREAMS-1:0] streamIrq,
  output logic                   pendAny,
  output logic                   matchOk,
  output logic                   fetchLast,
  output logic                   copyZero,
  output logic                   contAfter,
  output logic                   dpEnable
);
  // per-channel registers
  logic [31:0]       ctlReg  [NUM_STREAMS];
  logic [31:0]       cblReg  [NUM_STREAMS];
  logic [EIDX_W-1:0] lviReg  [NUM_STREAMS];
  logic [EIDX_W-1:0] lastIdx [NUM_STREAMS];
  logic [EIDX_W-1:0] entIdx  [NUM_STREAMS];
  logic [ADDR_W-1:0] bdlBase [NUM_STREAMS];
  logic [31:0]       lpib    [NUM_STREAMS];
  logic [31:0]       entOff  [NUM_STREAMS];
  logic [NUM_STREAMS-1:0] pending, loaded;
  logic [ADDR_W-1:0] dpBase;

  // descriptor table
  logic [ADDR_W-1:0] dAddr [NUM_STREAMS][MAX_ENTRIES];
  logic [31:0]       dLen  [NUM_STREAMS][MAX_ENTRIES];
  logic              dIoc  [NUM_STREAMS][MAX_ENTRIES];

  // working state of the active operation
  logic [SIDX_W-1:0] actIdx;
  logic [EIDX_W-1:0] fetchCnt;
  logic [31:0]       leftReg;
  logic [CNT_W-1:0]  budget;
  logic              irqFlag;

  // ---------------- channel selection ----------------
  logic [SIDX_W-1:0] pendIdx, matchIdx;
  logic              matchFound;

  always_comb begin
    pendIdx = '0;
    for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
      if (pending[i]) pendIdx = SIDX_W'(i);
    end
  end
  assign pendAny = |pending;

  always_comb begin
    logic [SIDX_W-1:0] cand;
    matchIdx   = '0;
    matchFound = 1'b0;
    for (int i = HALF - 1; i >= 0; i--) begin
      cand = SIDX_W'(xferOutput ? (HALF + i) : i);
      if (ctlReg[cand][23:20] == xferStreamNum) begin
        matchIdx   = cand;
        matchFound = 1'b1;
      end
    end
  end
  assign matchOk = matchFound && ctlReg[matchIdx][1] && loaded[matchIdx];

  // ---------------- chunk arithmetic ----------------
  logic [31:0] curLen, curOff, curLp, curCbl, roomCyc, roomEnt, copyLen;
  logic        curIoc, consumed;

  always_comb begin
    curLen  = dLen[actIdx][entIdx[actIdx]];
    curIoc  = dIoc[actIdx][entIdx[actIdx]];
    curOff  = entOff[actIdx];
    curLp   = lpib[actIdx];
    curCbl  = cblReg[actIdx];
    roomCyc = (curCbl > curLp) ? (curCbl - curLp) : 32'd0;
    roomEnt = (curLen > curOff) ? (curLen - curOff) : 32'd0;
    copyLen = leftReg;
    if (roomCyc < copyLen) copyLen = roomCyc;
    if (roomEnt < copyLen) copyLen = roomEnt;
    consumed = (curOff + copyLen) == curLen;
  end

  assign copyZero  = (copyLen == 32'd0);
  assign contAfter = (leftReg != copyLen) && (budget > CNT_W'(1));
  assign burstAddr = dAddr[actIdx][entIdx[actIdx]] + ADDR_W'(curOff);
  assign burstLen  = copyLen;
  assign memRdAddr = bdlBase[actIdx] + ADDR_W'({fetchCnt, 4'b0000});
  assign fetchLast = (fetchCnt == lastIdx[actIdx]);
  assign dpEnable  = dpBase[0];
  assign posWrAddr = {dpBase[ADDR_W-1:1], 1'b0} + ADDR_W'({actIdx, 3'b000});
  assign posWrData = lpib[actIdx];

  generate
    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_irq
      assign streamIrq[s] = ctlReg[s][CTL_IRQ_BIT];
    end
  endgenerate

  // ---------------- control-word write ----------------
  logic [31:0] wrOld, wrNew;
  logic        runRise, runFall;

  always_comb begin
    wrOld = ctlReg[regStream];
    if (strobe.raiseIrq && irqFlag && (actIdx == regStream))
      wrOld[CTL_IRQ_BIT] = 1'b1;
    wrNew = ((wrOld & ~CTL_RW_MASK) | (regWrData & CTL_RW_MASK)) & ~(regWrData & CTL_W1C_MASK);
    if (wrNew[0]) wrNew = CTL_FIFO_RDY;
    runRise = regWrEn && (regSel == SEL_CTL) && !wrOld[1] && wrNew[1];
    runFall = regWrEn && (regSel == SEL_CTL) && wrOld[1] && !wrNew[1];
  end

  // ---------------- register read ----------------
  always_comb begin
    case (regSel)
      SEL_CTL:    regRdData = ctlReg[regStream];
      SEL_CBL:    regRdData = cblReg[regStream];
      SEL_LVI:    regRdData = 32'(lviReg[regStream]);
      SEL_BDL_LO: regRdData = bdlBase[regStream][31:0];
      SEL_BDL_HI: regRdData = bdlBase[regStream][63:32];
      SEL_LPIB:   regRdData = lpib[regStream];
      SEL_DP_LO:  regRdData = dpBase[31:0];
      default:    regRdData = dpBase[63:32];
    endcase
  end

  // ---------------- state update ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_STREAMS; s++) begin
        ctlReg[s]  <= CTL_FIFO_RDY;
        cblReg[s]  <= '0;
        lviReg[s]  <= '0;
        lastIdx[s] <= '0;
        entIdx[s]  <= '0;
        bdlBase[s] <= '0;
        lpib[s]    <= '0;
        entOff[s]  <= '0;
      end
      pending  <= '0;
      loaded   <= '0;
      dpBase   <= '0;
      actIdx   <= '0;
      fetchCnt <= '0;
      leftReg  <= '0;
      budget   <= '0;
      irqFlag  <= 1'b0;
    end else begin
      if (strobe.latchLoad) begin
        actIdx   <= pendIdx;
        fetchCnt <= '0;
      end
      if (strobe.fetchStore) fetchCnt <= fetchCnt + EIDX_W'(1);
      if (strobe.fetchDone) begin
        loaded[actIdx]  <= 1'b1;
        pending[actIdx] <= 1'b0;
      end
      if (strobe.latchXfer) begin
        actIdx  <= matchIdx;
        leftReg <= xferLen;
        budget  <= CNT_W'(lastIdx[matchIdx]) + CNT_W'(1);
        irqFlag <= 1'b0;
      end
      if (strobe.chunkStep) begin
        leftReg <= leftReg - copyLen;
        budget  <= budget - CNT_W'(1);
        if (consumed) begin
          entOff[actIdx] <= '0;
          if (curIoc) irqFlag <= 1'b1;
          if (entIdx[actIdx] == lastIdx[actIdx]) begin
            entIdx[actIdx] <= '0;
            lpib[actIdx]   <= '0;
          end else begin
            entIdx[actIdx] <= entIdx[actIdx] + EIDX_W'(1);
            lpib[actIdx]   <= curLp + copyLen;
          end
        end else begin
          entOff[actIdx] <= curOff + copyLen;
          lpib[actIdx]   <= curLp + copyLen;
        end
      end
      if (strobe.raiseIrq && irqFlag) ctlReg[actIdx][CTL_IRQ_BIT] <= 1'b1;
      if (regWrEn) begin
        case (regSel)
          SEL_CTL: begin
            ctlReg[regStream] <= wrNew;
            if (runRise) begin
              pending[regStream] <= 1'b1;
              loaded[regStream]  <= 1'b0;
              lpib[regStream]    <= '0;
              entIdx[regStream]  <= '0;
              entOff[regStream]  <= '0;
              lastIdx[regStream] <= lviReg[regStream];
            end
            if (runFall) begin
              pending[regStream] <= 1'b0;
              loaded[regStream]  <= 1'b0;
            end
          end
          SEL_CBL:    cblReg[regStream] <= regWrData;
          SEL_LVI:    lviReg[regStream] <= regWrData[EIDX_W-1:0];
          SEL_BDL_LO: bdlBase[regStream][31:0] <= regWrData & BDL_LO_MASK;
          SEL_BDL_HI: bdlBase[regStream][63:32] <= regWrData;
          SEL_DP_LO:  dpBase[31:0] <= regWrData & DP_LO_MASK;
          SEL_DP_HI:  dpBase[63:32] <= regWrData;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fetchStore) begin
      dAddr[actIdx][fetchCnt] <= memRdData[63:0];
      dLen[actIdx][fetchCnt]  <= memRdData[95:64];
      dIoc[actIdx][fetchCnt]  <= memRdData[96];
    end
  end

  // R3
  burst_len_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    burstValid |-> (burstLen != 32'd0) && (burstLen <= leftReg));

  // R6
  pos_addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    posWrValid |-> (posWrAddr[2:0] == 3'b000));

  generate
    for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_chk
      // R4
      entry_idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
        entIdx[s] <= lastIdx[s]);
      // R7
      irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
        $rose(ctlReg[s][CTL_IRQ_BIT]) |-> ($past(strobe.raiseIrq) && ($past(actIdx) == SIDX_W'(s))));
    end
  endgenerate
endmodule

// File: rtl/dsdma_tracker.sv
module dsdma_tracker
  import dsdma_pkg::*;
#(
  parameter int NUM_STREAMS = 8,
  parameter int MAX_ENTRIES = 4,
  localparam int SIDX_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   regWrEn,
  input  logic [SIDX_W-1:0]      regStream,
  input  logic [2:0]             regSel,
  input  logic [31:0]            regWrData,
  output logic [31:0]            regRdData,
  output logic                   memRdReq,
  output logic [63:0]            memRdAddr,
  input  logic                   memRdAck,
  input  logic [96:0]            memRdData,
  input  logic                   xferReq,
  input  logic                   xferOutput,
  input  logic [3:0]             xferStreamNum,
  input  logic [31:0]            xferLen,
  output logic                   xferDone,
  output logic                   xferErr,
  output logic                   burstValid,
  input  logic                   burstReady,
  output logic [63:0]            burstAddr,
  output logic [31:0]            burstLen,
  output logic                   posWrValid,
  input  logic                   posWrReady,
  output logic [63:0]            posWrAddr,
  output logic [31:0]            posWrData,
  output logic [NUM_STREAMS-1:0] streamIrq
);
  ctrlStrobe_t strobe;
  logic pendAny, matchOk, fetchLast, copyZero, contAfter, dpEnable;

  dsdma_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .xferReq(xferReq), .matchOk(matchOk),
    .pendAny(pendAny), .fetchLast(fetchLast), .memRdAck(memRdAck),
    .copyZero(copyZero), .contAfter(contAfter), .dpEnable(dpEnable),
    .burstReady(burstReady), .posWrReady(posWrReady), .strobe(strobe),
    .memRdReq(memRdReq), .burstValid(burstValid), .posWrValid(posWrValid),
    .xferDone(xferDone), .xferErr(xferErr)
  );

  dsdma_datapath #(.NUM_STREAMS(NUM_STREAMS), .MAX_ENTRIES(MAX_ENTRIES)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .regWrEn(regWrEn), .regStream(regStream), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData),
    .xferOutput(xferOutput), .xferStreamNum(xferStreamNum), .xferLen(xferLen),
    .memRdData(memRdData), .burstValid(burstValid), .posWrValid(posWrValid),
    .memRdAddr(memRdAddr), .burstAddr(burstAddr), .burstLen(burstLen),
    .posWrAddr(posWrAddr), .posWrData(posWrData), .streamIrq(streamIrq),
    .pendAny(pendAny), .matchOk(matchOk), .fetchLast(fetchLast),
    .copyZero(copyZero), .contAfter(contAfter), .dpEnable(dpEnable)
  );
endmodule

// File: tb/dsdma_tracker_tb.sv
module dsdma_tracker_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regStream = '0;
  logic [2:0]  regSel = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memRdReq;
  logic [63:0] memRdAddr;
  logic        memRdAck = 1'b0;
  logic [96:0] memRdData = '0;
  logic        xferReq = 1'b0;
  logic        xferOutput = 1'b0;
  logic [3:0]  xferStreamNum = '0;
  logic [31:0] xferLen = '0;
  logic        xferDone, xferErr;
  logic        burstValid;
  logic        burstReady = 1'b1;
  logic [63:0] burstAddr;
  logic [31:0] burstLen;
  logic        posWrValid;
  logic        posWrReady = 1'b1;
  logic [63:0] posWrAddr;
  logic [31:0] posWrData;
  logic [7:0]  streamIrq;

  int checks = 0;
  int errors = 0;
  logic [63:0] fetchLog[$];
  logic [63:0] bAddrLog[$];
  logic [31:0] bLenLog[$];
  logic [63:0] pAddrLog[$];
  logic [31:0] pDataLog[$];

  always #2 clk = ~clk;

  dsdma_tracker dut_i (.*);

  function automatic logic [96:0] descData(input logic [63:0] a);
    case (a)
      64'h1000_0000: descData = {1'b0, 32'd300, 64'hA000};
      64'h1000_0010: descData = {1'b1, 32'd400, 64'hB000};
      64'h1000_0020: descData = {1'b0, 32'd300, 64'hC000};
      64'h3000_0000: descData = {1'b0, 32'd200, 64'hD000};
      default:       descData = {1'b0, 32'd64,  64'hE000};
    endcase
  endfunction

  always @(negedge clk) begin
    memRdAck  = memRdReq;
    memRdData = descData(memRdAddr);
    if (memRdReq) fetchLog.push_back(memRdAddr);
    if (burstValid && burstReady) begin
      bAddrLog.push_back(burstAddr);
      bLenLog.push_back(burstLen);
    end
    if (posWrValid && posWrReady) begin
      pAddrLog.push_back(posWrAddr);
      pDataLog.push_back(posWrData);
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWr(input int s, input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    regStream = 3'(s); regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRd(input int s, input logic [2:0] sel, output logic [31:0] d);
    @(negedge clk);
    regStream = 3'(s); regSel = sel;
    #1 d = regRdData;
  endtask

  task automatic clearLogs();
    fetchLog.delete(); bAddrLog.delete(); bLenLog.delete();
    pAddrLog.delete(); pDataLog.delete();
  endtask

  task automatic doXfer(input logic outDir, input int num, input int len, output logic err);
    clearLogs();
    @(negedge clk);
    xferOutput = outDir; xferStreamNum = 4'(num); xferLen = 32'(len); xferReq = 1'b1;
    do @(negedge clk); while (!xferDone);
    err = xferErr;
    xferReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] d;
    regRd(0, 3'd0, d); chk("R1 ctl0", d, 32'h2000_0000);
    regRd(7, 3'd0, d); chk("R1 ctl7", d, 32'h2000_0000);
    regRd(4, 3'd5, d); chk("R1 lpib", d, 0);
    chk("R1 irq", streamIrq, 0);
    chk("R1 idle", {memRdReq, burstValid, posWrValid, xferDone}, 0);
  endtask

  task automatic testStart();
    logic [31:0] d;
    regWr(4, 3'd1, 1000);
    regWr(4, 3'd2, 2);
    regWr(4, 3'd3, 32'h1000_007f);
    regWr(4, 3'd4, 0);
    regRd(4, 3'd3, d); chk("R12 bdl lo mask", d, 32'h1000_0000);
    clearLogs();
    regWr(4, 3'd0, (1 << 20) | 2);
    waitCycles(8);
    chk("R2 fetch count", fetchLog.size(), 3);
    if (fetchLog.size() == 3) begin
      chk("R2 fetch0", fetchLog[0], 64'h1000_0000);
      chk("R2 fetch1", fetchLog[1], 64'h1000_0010);
      chk("R2 fetch2", fetchLog[2], 64'h1000_0020);
    end
  endtask

  task automatic testFirstChunk();
    logic err; logic [31:0] d;
    doXfer(1'b1, 1, 250, err);
    chk("R3 err", err, 0);
    chk("R3 nburst", bAddrLog.size(), 1);
    if (bAddrLog.size() == 1) begin
      chk("R3 addr", bAddrLog[0], 64'hA000);
      chk("R3 len", bLenLog[0], 250);
    end
    chk("R6 no poswr", pAddrLog.size(), 0);
    regRd(4, 3'd5, d); chk("R3 lpib", d, 250);
  endtask

  task automatic testCrossEntry();
    logic err; logic [31:0] d;
    doXfer(1'b1, 1, 200, err);
    chk("R4 nburst", bAddrLog.size(), 2);
    if (bAddrLog.size() == 2) begin
      chk("R3 addr0", bAddrLog[0], 64'hA0FA); chk("R3 len0", bLenLog[0], 50);
      chk("R4 addr1", bAddrLog[1], 64'hB000); chk("R4 len1", bLenLog[1], 150);
    end
    regRd(4, 3'd5, d); chk("R4 lpib", d, 450);
    chk("R7 no irq", streamIrq[4], 0);
  endtask

  task automatic testPosAndIrq();
    logic err; logic [31:0] d;
    regWr(0, 3'd6, 32'h2000_00ff);
    regRd(0, 3'd6, d); chk("R12 dp lo mask", d, 32'h2000_0081);
    regWr(0, 3'd6, 32'h2000_0001);
    doXfer(1'b1, 1, 400, err);
    chk("R3 nburst", bAddrLog.size(), 2);
    if (bAddrLog.size() == 2) begin
      chk("R3 addr0", bAddrLog[0], 64'hB096); chk("R3 len0", bLenLog[0], 250);
      chk("R3 addr1", bAddrLog[1], 64'hC000); chk("R3 len1", bLenLog[1], 150);
    end
    chk("R6 npos", pAddrLog.size(), 1);
    if (pAddrLog.size() == 1) begin
      chk("R6 pos addr", pAddrLog[0], 64'h2000_0020);
      chk("R6 pos data", pDataLog[0], 850);
    end
    chk("R7 irq set", streamIrq[4], 1);
  endtask

  task automatic testIrqClear();
    logic [31:0] d;
    regWr(4, 3'd0, (1 << 20) | 2);
    regRd(4, 3'd0, d); chk("R7 w0 keeps", d, 32'h2410_0002);
    regWr(4, 3'd0, (1 << 26) | (1 << 20) | 2);
    regRd(4, 3'd0, d); chk("R7 w1 clears", d, 32'h2010_0002);
    chk("R7 irq out", streamIrq[4], 0);
  endtask

  task automatic testWrap();
    logic err; logic [31:0] d;
    doXfer(1'b1, 1, 1000, err);
    chk("R5 nburst", bAddrLog.size(), 3);
    if (bAddrLog.size() == 3) begin
      chk("R4 addr0", bAddrLog[0], 64'hC096); chk("R4 len0", bLenLog[0], 150);
      chk("R4 wrap addr", bAddrLog[1], 64'hA000); chk("R4 wrap len", bLenLog[1], 300);
      chk("R5 addr2", bAddrLog[2], 64'hB000); chk("R5 len2", bLenLog[2], 400);
    end
    regRd(4, 3'd5, d); chk("R4 lpib", d, 700);
    if (pDataLog.size() == 1) chk("R6 pos data", pDataLog[0], 700);
    else chk("R6 npos", pDataLog.size(), 1);
    chk("R7 irq again", streamIrq[4], 1);
  endtask

  task automatic testCyclicLimit();
    logic err; logic [31:0] d;
    regWr(0, 3'd1, 100);
    regWr(0, 3'd2, 0);
    regWr(0, 3'd3, 32'h3000_0000);
    regWr(0, 3'd0, (2 << 20) | 2);
    waitCycles(6);
    doXfer(1'b0, 2, 150, err);
    chk("R3 err", err, 0);
    chk("R3 nburst", bAddrLog.size(), 1);
    if (bLenLog.size() == 1) chk("R3 cyc limit", bLenLog[0], 100);
    if (pAddrLog.size() == 1) chk("R6 slot0", pAddrLog[0], 64'h2000_0000);
    else chk("R6 npos", pAddrLog.size(), 1);
    doXfer(1'b0, 2, 10, err);
    chk("R3 zero chunk no burst", bAddrLog.size(), 0);
    chk("R3 zero chunk done ok", err, 0);
    regRd(0, 3'd5, d); chk("R3 lpib held", d, 100);
  endtask

  task automatic testSelect();
    logic err;
    doXfer(1'b0, 1, 16, err);
    chk("R9 wrong dir err", err, 1);
    chk("R10 no burst", bAddrLog.size(), 0);
    regWr(6, 3'd1, 4096);
    regWr(6, 3'd0, (3 << 20) | 2);
    regWr(5, 3'd0, (3 << 20));
    waitCycles(6);
    doXfer(1'b1, 3, 32, err);
    chk("R9 lowest match idle err", err, 1);
    regWr(5, 3'd0, 1);
    doXfer(1'b1, 3, 32, err);
    chk("R9 match ok", err, 0);
    if (bAddrLog.size() == 1) begin
      chk("R9 addr", bAddrLog[0], 64'hE000); chk("R9 len", bLenLog[0], 32);
    end else chk("R9 nburst", bAddrLog.size(), 1);
    if (pAddrLog.size() == 1) chk("R6 slot6", pAddrLog[0], 64'h2000_0030);
  endtask

  task automatic testStreamReset();
    logic err; logic [31:0] d;
    regWr(4, 3'd0, 1);
    regRd(4, 3'd0, d); chk("R8 ctl reset", d, 32'h2000_0000);
    chk("R8 irq cleared", streamIrq[4], 0);
    doXfer(1'b1, 1, 16, err);
    chk("R10 no match err", err, 1);
    chk("R10 no poswr", pAddrLog.size(), 0);
  endtask

  task automatic testRestart();
    logic err; logic [31:0] d;
    regWr(0, 3'd0, (2 << 20));
    doXfer(1'b0, 2, 30, err);
    chk("R10 stopped err", err, 1);
    regRd(0, 3'd5, d); chk("R10 lpib unchanged", d, 100);
    regWr(0, 3'd0, (2 << 20) | 2);
    waitCycles(6);
    regRd(0, 3'd5, d); chk("R11 lpib zero", d, 0);
    doXfer(1'b0, 2, 30, err);
    chk("R11 err", err, 0);
    if (bAddrLog.size() == 1) begin
      chk("R11 addr", bAddrLog[0], 64'hD000); chk("R11 len", bLenLog[0], 30);
    end else chk("R11 nburst", bAddrLog.size(), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);
    testReset();
    testStart();
    testFirstChunk();
    testCrossEntry();
    testPosAndIrq();
    testIrqClear();
    testWrap();
    testCyclicLimit();
    testSelect();
    testStreamReset();
    testRestart();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule